// File: doc/BRIEF.md
# Armable Interrupt Request Controller

This block gathers interrupt requests from a number of sources, grouped into levels of 32 sources each. Every source owns a pending bit and an enable bit. The block raises a single interrupt line whenever at least one source is both pending and enabled. On an acknowledge strobe it picks the winning source in fixed priority order. One cycle later it returns that source's device number from a loadable mapping table. It also drops the winner's pending bit.

Devices raise and drop their own request bits through set and clear vectors. A per-source control port takes a two-bit command that enables, disables or disarms one source. The same port also reports whether that source is still armed. A small combinational helper turns a two-bit control field into a keep, set, clear or complement of a single bit. The mapping table is written one entry at a time through its own write port.

Top module: `irqc_top`

## Requirements
- R1: `irq_out` is high exactly when some source has both its pending bit and its enable bit set. It follows the registered state, so a stimulus applied before clock edge k is visible after edge k.
- R2: The acknowledge winner is the enabled pending source with the lowest flat index, level × 32 + bit. Level 0 therefore beats level 1, and within a level bit 0 beats bit 31. Sources that are pending but disabled never win.
- R3: When `ack` is high at an edge, `ack_valid` is high for the following cycle and `ack_dev` holds the table entry at the winner's index. Only the winner's pending bit is cleared; every other pending bit is kept.
- R4: An acknowledge with no source both pending and enabled returns `ack_dev` = 0 and clears nothing.
- R5: Command 2'b01 (enable) sets the addressed source's enable bit, and command 2'b10 (disable) clears it while keeping its pending bit. For both commands `armed_out` is 1.
- R6: Command 2'b11 (disarm) clears both the enable bit and the pending bit of the addressed source, and `armed_out` is 0.
- R7: Command 2'b00, or `ctl_valid` low, changes no state, and `armed_out` equals `armed_in`.
- R8: The field helper gives `fld_new` = `fld_old` for code 2'b00, 1 for 2'b01, 0 for 2'b10 and the complement of `fld_old` for 2'b11.
- R9: Reset clears every pending bit, sets every enable bit, clears every table entry to 0 and drops `ack_valid`.
- R10: When a `req_set` bit is high at an edge, that source is pending after the edge. This holds even if the same edge also acknowledges it, clears it through `req_clr`, or disarms it.
- R11: A `req_clr` bit high at an edge, with no set of the same bit, clears that pending bit.
- R12: `map_we` writes `map_dev` into entry `map_idx` at the edge. An acknowledge reads the table as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set | input | NUM_LEVELS*32 | Per-source request set |
| req_clr | input | NUM_LEVELS*32 | Per-source request clear |
| ctl_valid | input | 1 | Control command strobe |
| ctl_cmd | input | 2 | 00 none, 01 enable, 10 disable, 11 disarm |
| ctl_src | input | clog2(NUM_LEVELS*32) | Source addressed by the command |
| armed_in | input | 1 | Present armed state of the addressed source |
| armed_out | output | 1 | Armed state after the command |
| irq_out | output | 1 | Any source pending and enabled |
| ack | input | 1 | Acknowledge strobe |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_dev | output | DEV_W | Device number of the acknowledged source, 0 if none |
| map_we | input | 1 | Mapping table write enable |
| map_idx | input | clog2(NUM_LEVELS*32) | Mapping table entry to write |
| map_dev | input | DEV_W | Device number to store |
| fld_code | input | 2 | Two-bit control field |
| fld_old | input | 1 | Present value of the controlled bit |
| fld_new | output | 1 | Decoded new value of the bit |

## Verification
Priority is first tried with a single source at a time across all 64 positions. This shows that the index-to-table mapping and the clearing of the winner are right at every bit and both levels. Pairs of sources follow, some within one level and some across levels. They separate a correct lowest-index choice from a highest-index or level-blind one. The enable paths are tried with a disabled low source next to an enabled high one, and with a disarm followed by a re-enable. These tell a disable, which keeps the request, apart from a disarm, which drops it. Finally, same-edge collisions of set with acknowledge and of set with clear show which update wins. The command and field decoders are swept over every code.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned LVL_W   = 32;
    localparam int unsigned LBIT_W  = $clog2(LVL_W);

    typedef enum logic [1:0] {
        CMD_NONE    = 2'b00,
        CMD_ENABLE  = 2'b01,
        CMD_DISABLE = 2'b10,
        CMD_DISARM  = 2'b11
    } irq_cmd_e;

    typedef enum logic [1:0] {
        FLD_KEEP = 2'b00,
        FLD_SET  = 2'b01,
        FLD_CLR  = 2'b10,
        FLD_FLIP = 2'b11
    } fld_op_e;

    // Decode a two-bit control field against the old bit value.
    function automatic logic fld_apply(input fld_op_e op, input logic old);
        logic r;
        case (op)
            FLD_SET:  r = 1'b1;
            FLD_CLR:  r = 1'b0;
            FLD_FLIP: r = ~old;
            default:  r = old;
        endcase
        return r;
    endfunction

    // Armed report of a source after a control command.
    function automatic logic cmd_armed(input irq_cmd_e cmd, input logic cur);
        logic r;
        case (cmd)
            CMD_ENABLE, CMD_DISABLE: r = 1'b1;
            CMD_DISARM:              r = 1'b0;
            default:                 r = cur;
        endcase
        return r;
    endfunction

    // Lowest set bit of one level word.
    function automatic logic [LBIT_W-1:0] first_bit(input logic [LVL_W-1:0] w);
        logic [LBIT_W-1:0] r;
        r = '0;
        for (int i = LVL_W - 1; i >= 0; i--) begin
            if (w[i]) r = LBIT_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irqc_state.sv
module irqc_state
    import irqc_pkg::*;
#(
    parameter int unsigned N_SRC = 64,
    parameter int unsigned SRC_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] req_set,
    input  logic [N_SRC-1:0] req_clr,
    input  logic [N_SRC-1:0] ack_clr,
    input  logic             ctl_valid,
    input  irq_cmd_e         ctl_cmd,
    input  logic [SRC_W-1:0] ctl_src,
    output logic [N_SRC-1:0] req_q,
    output logic [N_SRC-1:0] enb_q
);

    logic [N_SRC-1:0] src_mask;
    logic [N_SRC-1:0] drop_mask;
    logic [N_SRC-1:0] req_nxt;
    logic [N_SRC-1:0] enb_nxt;

    always_comb begin
        src_mask = '0;
        for (int i = 0; i < int'(N_SRC); i++) begin
            if (ctl_valid && (int'(ctl_src) == i)) src_mask[i] = 1'b1;
        end
    end

    always_comb begin
        drop_mask = req_clr | ack_clr;
        if (ctl_cmd == CMD_DISARM) drop_mask = drop_mask | src_mask;
        // Device sets take priority over every clearing source.
        req_nxt = (req_q & ~drop_mask) | req_set;
    end

    always_comb begin
        case (ctl_cmd)
            CMD_ENABLE:              enb_nxt = enb_q | src_mask;
            CMD_DISABLE, CMD_DISARM: enb_nxt = enb_q & ~src_mask;
            default:                 enb_nxt = enb_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            enb_q <= '1;
        end else begin
            req_q <= req_nxt;
            enb_q <= enb_nxt;
        end
    end

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_LEVELS = 2,
    parameter int unsigned SRC_W      = 6
) (
    input  logic [NUM_LEVELS*LVL_W-1:0] pend,
    output logic                        hit,
    output logic [SRC_W-1:0]            win_idx,
    output logic [NUM_LEVELS*LVL_W-1:0] win_onehot
);

    localparam int unsigned N_SRC = NUM_LEVELS * LVL_W;

    logic [NUM_LEVELS-1:0]  lvl_hit;
    logic [LBIT_W-1:0]      lvl_bit [NUM_LEVELS];

    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
        logic [LVL_W-1:0] word;
        assign word       = pend[l*LVL_W +: LVL_W];
        assign lvl_hit[l] = |word;
        assign lvl_bit[l] = first_bit(word);
    end

    always_comb begin
        win_idx = '0;
        for (int l = NUM_LEVELS - 1; l >= 0; l--) begin
            if (lvl_hit[l]) win_idx = SRC_W'(l * LVL_W) + SRC_W'(lvl_bit[l]);
        end
        hit        = |lvl_hit;
        win_onehot = hit ? (N_SRC'(1) << win_idx) : '0;
    end

endmodule

// File: rtl/irqc_map.sv
module irqc_map #(
    parameter int unsigned N_SRC = 64,
    parameter int unsigned SRC_W = 6,
    parameter int unsigned DEV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SRC_W-1:0] widx,
    input  logic [DEV_W-1:0] wdata,
    input  logic             rd_en,
    input  logic             rd_hit,
    input  logic [SRC_W-1:0] ridx,
    output logic             rvalid,
    output logic [DEV_W-1:0] rdata
);

    logic [DEV_W-1:0] tbl [N_SRC];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(N_SRC); i++) tbl[i] <= '0;
        end else if (we && (int'(widx) < int'(N_SRC))) begin
            tbl[widx] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) rdata <= rd_hit ? tbl[ridx] : '0;
        end
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_LEVELS = 2,
    parameter int unsigned DEV_W      = 8
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic [NUM_LEVELS*LVL_W-1:0]               req_set,
    input  logic [NUM_LEVELS*LVL_W-1:0]               req_clr,
    input  logic                                      ctl_valid,
    input  logic [1:0]                                ctl_cmd,
    input  logic [$clog2(NUM_LEVELS*LVL_W)-1:0]       ctl_src,
    input  logic                                      armed_in,
    output logic                                      armed_out,
    output logic                                      irq_out,
    input  logic                                      ack,
    output logic                                      ack_valid,
    output logic [DEV_W-1:0]                          ack_dev,
    input  logic                                      map_we,
    input  logic [$clog2(NUM_LEVELS*LVL_W)-1:0]       map_idx,
    input  logic [DEV_W-1:0]                          map_dev,
    input  logic [1:0]                                fld_code,
    input  logic                                      fld_old,
    output logic                                      fld_new
);

    localparam int unsigned N_SRC = NUM_LEVELS * LVL_W;
    localparam int unsigned SRC_W = $clog2(N_SRC);

    irq_cmd_e         cmd;
    logic [N_SRC-1:0] req_q;
    logic [N_SRC-1:0] enb_q;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] win_onehot;
    logic [N_SRC-1:0] ack_clr;
    logic [SRC_W-1:0] win_idx;
    logic             win_hit;

    assign cmd = irq_cmd_e'(ctl_valid ? ctl_cmd : 2'b00);

    irqc_state #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_state (
        .clk       (clk),
        .rst       (rst),
        .req_set   (req_set),
        .req_clr   (req_clr),
        .ack_clr   (ack_clr),
        .ctl_valid (ctl_valid),
        .ctl_cmd   (cmd),
        .ctl_src   (ctl_src),
        .req_q     (req_q),
        .enb_q     (enb_q)
    );

    assign pend = req_q & enb_q;

    irqc_prio #(.NUM_LEVELS(NUM_LEVELS), .SRC_W(SRC_W)) u_prio (
        .pend       (pend),
        .hit        (win_hit),
        .win_idx    (win_idx),
        .win_onehot (win_onehot)
    );

    assign ack_clr = ack ? win_onehot : '0;
    assign irq_out = win_hit;

    irqc_map #(.N_SRC(N_SRC), .SRC_W(SRC_W), .DEV_W(DEV_W)) u_map (
        .clk    (clk),
        .rst    (rst),
        .we     (map_we),
        .widx   (map_idx),
        .wdata  (map_dev),
        .rd_en  (ack),
        .rd_hit (win_hit),
        .ridx   (win_idx),
        .rvalid (ack_valid),
        .rdata  (ack_dev)
    );

    assign armed_out = cmd_armed(cmd, armed_in);
    assign fld_new   = fld_apply(fld_op_e'(fld_code), fld_old);

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_LEVELS = 2,
    parameter int unsigned DEV_W      = 8
) (
    input logic                                clk,
    input logic                                rst,
    input logic [NUM_LEVELS*LVL_W-1:0]         req_set,
    input logic                                ctl_valid,
    input logic [1:0]                          ctl_cmd,
    input logic [$clog2(NUM_LEVELS*LVL_W)-1:0] ctl_src,
    input logic                                armed_in,
    input logic                                armed_out,
    input logic                                irq_out,
    input logic                                ack,
    input logic                                ack_valid,
    input logic [DEV_W-1:0]                    ack_dev,
    input logic [1:0]                          fld_code,
    input logic                                fld_old,
    input logic                                fld_new,
    input logic [NUM_LEVELS*LVL_W-1:0]         req_q,
    input logic [NUM_LEVELS*LVL_W-1:0]         enb_q
);

    // R3: result strobe follows the acknowledge by one cycle
    a_r3_ack_valid_rise: assert property (@(posedge clk) disable iff (rst)
        ack |=> ack_valid);
    a_r3_ack_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !ack |=> !ack_valid);

    // R4: acknowledge with nothing eligible returns device 0
    a_r4_idle_ack_zero: assert property (@(posedge clk) disable iff (rst)
        (ack && !irq_out) |=> (ack_dev == '0));

    // R6: disarm without a competing set drops request and enable
    a_r6_disarm_clears: assert property (@(posedge clk) disable iff (rst)
        (ctl_valid && ctl_cmd == 2'b11 && !req_set[ctl_src])
        |=> (!req_q[$past(ctl_src)] && !enb_q[$past(ctl_src)]));

    // R5: enable and disable report armed
    a_r5_armed_report: assert property (@(posedge clk) disable iff (rst)
        (ctl_valid && (ctl_cmd == 2'b01 || ctl_cmd == 2'b10)) |-> armed_out);

    // R7: no command passes the armed state through
    a_r7_armed_pass: assert property (@(posedge clk) disable iff (rst)
        (!ctl_valid || ctl_cmd == 2'b00) |-> (armed_out == armed_in));

    // R8: complement code always changes the bit
    a_r8_field_flip: assert property (@(posedge clk) disable iff (rst)
        (fld_code == 2'b11) |-> (fld_new != fld_old));

    // R10: a device set always survives the edge
    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|req_set) |=> ((req_q & $past(req_set)) == $past(req_set)));

endmodule

bind irqc_top irqc_chk #(.NUM_LEVELS(NUM_LEVELS), .DEV_W(DEV_W)) u_chk (.*);

// File: tb/test_irqc_top.sv
module test_irqc_top;

    localparam int NL = 2;
    localparam int N  = NL * 32;
    localparam int SW = $clog2(N);
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  req_set, req_clr;
    logic          ctl_valid;
    logic [1:0]    ctl_cmd;
    logic [SW-1:0] ctl_src;
    logic          armed_in, armed_out, irq_out;
    logic          ack, ack_valid;
    logic [DW-1:0] ack_dev;
    logic          map_we;
    logic [SW-1:0] map_idx;
    logic [DW-1:0] map_dev;
    logic [1:0]    fld_code;
    logic          fld_old, fld_new;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irqc_top #(.NUM_LEVELS(NL), .DEV_W(DW)) i_irqc_top (.*);

    function automatic int dev_of(int i);
        return (((i * 5) ^ 8'h9C) | 1) & 8'hFF;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_src(int a, int b);
        req_set = '0;
        if (a >= 0) req_set[a] = 1'b1;
        if (b >= 0) req_set[b] = 1'b1;
        step();
        req_set = '0;
    endtask

    task automatic do_ack(output int dev, output bit vld);
        ack = 1'b1;
        step();
        ack = 1'b0;
        dev = int'(ack_dev);
        vld = ack_valid;
    endtask

    task automatic do_cmd(int s, logic [1:0] c);
        ctl_valid = 1'b1; ctl_cmd = c; ctl_src = SW'(s);
        step();
        ctl_valid = 1'b0; ctl_cmd = 2'b00;
    endtask

    task automatic expect_ack(int exp, string req);
        int d; bit v;
        do_ack(d, v);
        chk(v == 1'b1, req, int'(v), 1);
        chk(d == exp, req, d, exp);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_set = '0; req_clr = '0; ctl_valid = 1'b0; ctl_cmd = 2'b00;
        ctl_src = '0; armed_in = 1'b0; ack = 1'b0; map_we = 1'b0; map_idx = '0;
        map_dev = '0; fld_code = 2'b00; fld_old = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset state
        chk(irq_out == 1'b0, "R9 irq after reset", int'(irq_out), 0);
        chk(ack_valid == 1'b0, "R9 ack_valid after reset", int'(ack_valid), 0);
        expect_ack(0, "R4 empty ack");
        set_src(63, -1);
        chk(irq_out == 1'b1, "R9 enables set by reset", int'(irq_out), 1);
        expect_ack(0, "R9 table cleared by reset");
        chk(irq_out == 1'b0, "R3 winner cleared", int'(irq_out), 1'b0);

        // R12: program the table
        for (int i = 0; i < N; i++) begin
            map_we = 1'b1; map_idx = SW'(i); map_dev = DW'(dev_of(i));
            step();
        end
        map_we = 1'b0;

        // R1 R3: single-source sweep
        for (int s = 0; s < N; s++) begin
            set_src(s, -1);
            chk(irq_out == 1'b1, "R1 single pending", int'(irq_out), 1);
            expect_ack(dev_of(s), "R3 single source device");
            chk(irq_out == 1'b0, "R3 single cleared", int'(irq_out), 0);
        end

        // R2: pairs, within and across levels
        for (int s = 0; s < N; s++) begin
            int t, lo, hi;
            t = (s * 13 + 7) % N;
            if (t != s) begin
                lo = (s < t) ? s : t;
                hi = (s < t) ? t : s;
                set_src(s, t);
                expect_ack(dev_of(lo), "R2 lower index first");
                chk(irq_out == 1'b1, "R3 other request kept", int'(irq_out), 1);
                expect_ack(dev_of(hi), "R2 higher index second");
                chk(irq_out == 1'b0, "R1 all served", int'(irq_out), 0);
            end
        end

        // R2 R5: disabled source never wins; disable keeps the request
        do_cmd(3, 2'b10);
        set_src(3, 50);
        expect_ack(dev_of(50), "R2 disabled skipped");
        chk(irq_out == 1'b0, "R5 disabled pending masked", int'(irq_out), 0);
        expect_ack(0, "R4 only disabled pending");
        do_cmd(3, 2'b01);
        chk(irq_out == 1'b1, "R5 request kept across disable", int'(irq_out), 1);
        expect_ack(dev_of(3), "R5 re-enabled source served");

        // R6: disarm drops pending
        set_src(40, -1);
        do_cmd(40, 2'b11);
        chk(irq_out == 1'b0, "R6 disarm masks", int'(irq_out), 0);
        do_cmd(40, 2'b01);
        chk(irq_out == 1'b0, "R6 disarm dropped request", int'(irq_out), 0);
        expect_ack(0, "R6 nothing left after disarm");

        // R7: command 00 and strobe low change nothing
        set_src(20, -1);
        do_cmd(20, 2'b00);
        ctl_valid = 1'b0; ctl_cmd = 2'b11; ctl_src = SW'(20);
        step();
        ctl_cmd = 2'b00;
        chk(irq_out == 1'b1, "R7 no-op commands", int'(irq_out), 1);
        expect_ack(dev_of(20), "R7 source still served");

        // R5 R6 R7: armed report sweep, withdrawn before the edge
        for (int c = 0; c < 4; c++) begin
            for (int a = 0; a < 2; a++) begin
                int e;
                ctl_valid = 1'b1; ctl_cmd = 2'(c); ctl_src = SW'(10); armed_in = a[0];
                #1;
                e = (c == 1 || c == 2) ? 1 : (c == 3) ? 0 : a;
                chk(armed_out == e[0], "R5 R6 R7 armed report", int'(armed_out), e);
                ctl_valid = 1'b0;
                #0.1;
                chk(armed_out == a[0], "R7 strobe low passes", int'(armed_out), a);
                ctl_cmd = 2'b00;
                @(negedge clk);
            end
        end

        // R8: field helper, all codes
        for (int c = 0; c < 4; c++) begin
            for (int o = 0; o < 2; o++) begin
                int e;
                fld_code = 2'(c); fld_old = o[0];
                #1;
                e = (c == 0) ? o : (c == 1) ? 1 : (c == 2) ? 0 : (1 - o);
                chk(fld_new == e[0], "R8 field decode", int'(fld_new), e);
            end
        end

        // R10: set beats acknowledge-clear at the same edge
        @(negedge clk);
        set_src(7, -1);
        req_set[7] = 1'b1; ack = 1'b1;
        step();
        req_set = '0; ack = 1'b0;
        chk(int'(ack_dev) == dev_of(7), "R10 ack served", int'(ack_dev), dev_of(7));
        chk(irq_out == 1'b1, "R10 set beats ack clear", int'(irq_out), 1);
        // R10: set beats clear at the same edge
        req_set[7] = 1'b1; req_clr[7] = 1'b1;
        step();
        req_set = '0; req_clr = '0;
        chk(irq_out == 1'b1, "R10 set beats clear", int'(irq_out), 1);

        // R11: clear input drops request
        req_clr[7] = 1'b1;
        step();
        req_clr = '0;
        chk(irq_out == 1'b0, "R11 clear drops request", int'(irq_out), 0);

        // R12: write and acknowledge at the same edge read the old entry
        set_src(33, -1);
        map_we = 1'b1; map_idx = SW'(33); map_dev = 8'h5A; ack = 1'b1;
        step();
        map_we = 1'b0; ack = 1'b0;
        chk(int'(ack_dev) == dev_of(33), "R12 old entry on collision", int'(ack_dev), dev_of(33));
        set_src(33, -1);
        expect_ack(8'h5A, "R12 new entry");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule